// File: doc/BRIEF.md
# Multi-Channel UART Interrupt Aggregator

This block gathers interrupt requests from four UART channels and presents them to the host as one read-only 32-bit status word. Each channel raises requests from four sources: line status, receive data or timeout, transmit empty, and modem status. Each request sets a sticky flag. The flag stays set until that channel's own acknowledge input fires, which stands for the host reading the channel's source register.

The low byte of the word has one pending bit per channel. A packed field above the low byte holds a 3-bit priority-encoded source code for each channel. A single read therefore tells the host which channels need service and why. A combined interrupt output is the OR of everything pending.

The block also watches the per-channel sleep flags. This is done by a four-state machine:

| State | Meaning |
|---|---|
| `WK_AWAKE` | Idle, not armed. |
| `WK_ASLEEP` | Armed, because all channels were seen asleep at once. |
| `WK_PEND` | Wake-up interrupt pending. |
| `WK_PEND_ASLEEP` | Wake-up interrupt pending, and all channels asleep again. |

The transitions are:

| From | To | Condition |
|---|---|---|
| `WK_AWAKE` | `WK_ASLEEP` | `sleep` is all ones. |
| `WK_ASLEEP` | `WK_PEND` | Wake condition: `wake_evt` is high, or any sleep flag is low. |
| `WK_PEND` | `WK_AWAKE` | Low-lane read. |
| `WK_PEND` | `WK_ASLEEP` | Low-lane read with all channels asleep. |
| `WK_PEND` | `WK_PEND_ASLEEP` | All channels asleep, no low-lane read. |
| `WK_PEND_ASLEEP` | `WK_PEND` | Wake condition. |
| `WK_PEND_ASLEEP` | `WK_ASLEEP` | Low-lane read with no wake condition. |

Top module: `uart_irq_aggregator`

## Requirements
- R1: After reset, `status` is 0x00000000 and `irq` is 0.
- R2: `status[n]` (n = 0..3) is 1 while channel n has any sticky source flag set. `status[0]` is also 1 while the wake-up interrupt is pending.
- R3: Channel n's source code sits at `status[8+3n +: 3]`. The code is 1 for line status, 2 for receive, 3 for transmit, 4 for modem status and 0 for none. When several sources are set, the lowest code wins.
- R4: Bits [31:20] and bits [7:4] of `status` always read 0.
- R5: A request sets its flag on the next clock edge, and the flag holds until `ack[n]`. `ack[n]` clears all of channel n's flags on the next edge. A request in the same cycle as the ack is kept.
- R6: A host read (`rd_stb`, any `rd_lane`) leaves every channel's pending bit and source code unchanged.
- R7: Once all four `sleep` bits have been 1 together, a later cycle with `wake_evt` high or any sleep bit 0 sets the wake-up interrupt on the next edge. The wake-up interrupt shows as code 7 in channel 0's field and sets `status[0]`.
- R8: If the all-asleep condition was never reached, `wake_evt` and changes on the sleep flags do not raise the wake-up interrupt.
- R9: The wake-up interrupt stays pending until a cycle with `rd_stb` and `rd_lane[0]` both high. Reads of the other byte lanes do not clear it.
- R10: A low-lane read in the same cycle as a new wake condition leaves the wake-up interrupt pending.
- R11: `irq` equals the OR of `status[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_line | input | 4 | Line-status request per channel |
| req_rx | input | 4 | Receive data/timeout request per channel |
| req_tx | input | 4 | Transmit-empty request per channel |
| req_modem | input | 4 | Modem-status request per channel |
| ack | input | 4 | Per-channel acknowledge (source register read) |
| sleep | input | 4 | Per-channel sleep flag |
| wake_evt | input | 1 | Device wake event |
| rd_stb | input | 1 | Host read strobe for the status word |
| rd_lane | input | 4 | Byte lanes enabled during the read |
| status | output | 32 | Aggregate interrupt status word |
| irq | output | 1 | Combined interrupt request |

## Verification
A lost sticky flag makes a pending bit and its code field drop to zero one cycle after the fault, with no ack in between. A flag that fails to clear keeps the bit set one cycle after an ack. A wrong wake-machine state appears within a cycle of the next sleep or read event in one of three ways: a spurious code 7 in channel 0's field, a missing code 7, or a code 7 that survives a low-lane read. The reference model compares every field of the word and `irq` on every clock, so any such divergence is reported in the cycle it becomes visible.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int SRC_N  = 4;
    localparam int CODE_W = 3;

    // source index order inside a channel: also the priority order
    localparam int SRC_LINE  = 0;
    localparam int SRC_RX    = 1;
    localparam int SRC_TX    = 2;
    localparam int SRC_MODEM = 3;

    localparam logic [CODE_W-1:0] CODE_NONE = 3'd0;
    localparam logic [CODE_W-1:0] CODE_WAKE = 3'd7;

    typedef enum logic [1:0] {
        WK_AWAKE,
        WK_ASLEEP,
        WK_PEND,
        WK_PEND_ASLEEP
    } wake_st_t;
endpackage

// File: rtl/irq_src_chan.sv
module irq_src_chan
    import irq_agg_pkg::*;
#(
    parameter int NSRC = SRC_N,
    parameter int CW   = CODE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    input  logic            ack,
    output logic            pend,
    output logic [CW-1:0]   code
);
    logic [NSRC-1:0] flags;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (ack) begin
            flags <= req;
        end else begin
            flags <= flags | req;
        end
    end

    // lowest index wins; code = index + 1
    always_comb begin
        code = CODE_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (flags[i]) code = CW'(i + 1);
        end
    end

    assign pend = |flags;
endmodule

// File: rtl/irq_wake_fsm.sv
module irq_wake_fsm
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] sleep,
    input  logic              wake_evt,
    input  logic              low_rd,
    output logic              wake_pend,
    output logic              armed
);
    wake_st_t st, st_nx;
    logic all_asleep, wake_cond;

    assign all_asleep = &sleep;
    assign wake_cond  = wake_evt | ~all_asleep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= WK_AWAKE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            WK_AWAKE: begin
                if (all_asleep) st_nx = WK_ASLEEP;
            end
            WK_ASLEEP: begin
                if (wake_cond) st_nx = WK_PEND;
            end
            WK_PEND: begin
                if (low_rd && all_asleep) st_nx = WK_ASLEEP;
                else if (low_rd)          st_nx = WK_AWAKE;
                else if (all_asleep)      st_nx = WK_PEND_ASLEEP;
            end
            WK_PEND_ASLEEP: begin
                if (wake_cond)   st_nx = WK_PEND;
                else if (low_rd) st_nx = WK_ASLEEP;
            end
            default: st_nx = WK_AWAKE;
        endcase
    end

    always_comb begin
        wake_pend = 1'b0;
        armed     = 1'b0;
        unique case (st)
            WK_AWAKE:       ;
            WK_ASLEEP:      armed = 1'b1;
            WK_PEND:        wake_pend = 1'b1;
            WK_PEND_ASLEEP: begin
                wake_pend = 1'b1;
                armed     = 1'b1;
            end
            default:        ;
        endcase
    end
endmodule

// File: rtl/irq_status_pack.sv
module irq_status_pack
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CW     = CODE_W,
    parameter int WORD_W = 32
) (
    input  logic [NUM_CH-1:0]    pend,
    input  logic [NUM_CH*CW-1:0] codes,
    input  logic                 wake,
    output logic [WORD_W-1:0]    word
);
    localparam int FIELD_LO = 8;
    localparam int FIELD_HI = FIELD_LO + NUM_CH * CW;

    logic [NUM_CH-1:0]    bits;
    logic [NUM_CH*CW-1:0] fields;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        if (n == 0) begin : g_wake
            assign bits[n]           = pend[n] | wake;
            assign fields[n*CW +: CW] = wake ? CODE_WAKE : codes[n*CW +: CW];
        end else begin : g_plain
            assign bits[n]           = pend[n];
            assign fields[n*CW +: CW] = codes[n*CW +: CW];
        end
    end

    always_comb begin
        word = '0;
        word[NUM_CH-1:0]          = bits;
        word[FIELD_HI-1:FIELD_LO] = fields;
    end
endmodule

// File: rtl/uart_irq_aggregator.sv
module uart_irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_line,
    input  logic [NUM_CH-1:0] req_rx,
    input  logic [NUM_CH-1:0] req_tx,
    input  logic [NUM_CH-1:0] req_modem,
    input  logic [NUM_CH-1:0] ack,
    input  logic [NUM_CH-1:0] sleep,
    input  logic              wake_evt,
    input  logic              rd_stb,
    input  logic [3:0]        rd_lane,
    output logic [WORD_W-1:0] status,
    output logic              irq
);
    logic [NUM_CH-1:0]        pend;
    logic [NUM_CH*CODE_W-1:0] codes;
    logic                     wake_pend, armed, low_rd;

    assign low_rd = rd_stb & rd_lane[0];

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
        logic [SRC_N-1:0] req_v;
        always_comb begin
            req_v            = '0;
            req_v[SRC_LINE]  = req_line[n];
            req_v[SRC_RX]    = req_rx[n];
            req_v[SRC_TX]    = req_tx[n];
            req_v[SRC_MODEM] = req_modem[n];
        end
        irq_src_chan #(.NSRC(SRC_N), .CW(CODE_W)) u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (req_v),
            .ack  (ack[n]),
            .pend (pend[n]),
            .code (codes[n*CODE_W +: CODE_W])
        );
    end

    irq_wake_fsm #(.NUM_CH(NUM_CH)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .wake_evt (wake_evt),
        .low_rd   (low_rd),
        .wake_pend(wake_pend),
        .armed    (armed)
    );

    irq_status_pack #(.NUM_CH(NUM_CH), .CW(CODE_W), .WORD_W(WORD_W)) u_pack (
        .pend (pend),
        .codes(codes),
        .wake (wake_pend),
        .word (status)
    );

    assign irq = (|pend) | wake_pend;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
    parameter int NUM_CH = 4,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] req_line,
    input logic [NUM_CH-1:0] req_rx,
    input logic [NUM_CH-1:0] req_tx,
    input logic [NUM_CH-1:0] req_modem,
    input logic [NUM_CH-1:0] ack,
    input logic [NUM_CH-1:0] sleep,
    input logic              wake_evt,
    input logic              rd_stb,
    input logic [3:0]        rd_lane,
    input logic [WORD_W-1:0] status,
    input logic              irq,
    input logic              wake_pend,
    input logic              armed
);
    localparam int FIELD_HI = 8 + NUM_CH * 3;

    logic [NUM_CH-1:0] req_any;
    assign req_any = req_line | req_rx | req_tx | req_modem;

    p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[WORD_W-1:FIELD_HI] == '0) && (status[7:NUM_CH] == '0));

    p_irq_or_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|status[NUM_CH-1:0]));

    p_wake_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pend |-> (status[10:8] == 3'd7) && status[0]);

    p_wake_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pend && !(rd_stb && rd_lane[0]) |=> wake_pend);

    p_no_wake_unarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !armed && !wake_pend |=> !wake_pend);

    p_rd_race_r10: assert property (@(posedge clk) disable iff (!rst_n)
        armed && (wake_evt || !(&sleep)) |=> wake_pend);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            status[n] && !ack[n] && ((n != 0) || !wake_pend) |=> status[n]);
        p_ack_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ack[n] && !req_any[n] |=> !status[n] || ((n == 0) && wake_pend));
    end
endmodule

bind uart_irq_aggregator irq_agg_chk #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_irq_agg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_line (req_line),
    .req_rx   (req_rx),
    .req_tx   (req_tx),
    .req_modem(req_modem),
    .ack      (ack),
    .sleep    (sleep),
    .wake_evt (wake_evt),
    .rd_stb   (rd_stb),
    .rd_lane  (rd_lane),
    .status   (status),
    .irq      (irq),
    .wake_pend(wake_pend),
    .armed    (armed)
);

// File: tb/test_uart_irq_aggregator.sv
module test_uart_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_line = '0, req_rx = '0, req_tx = '0, req_modem = '0;
    logic [3:0]  ack = '0, sleep = '0, rd_lane = '0;
    logic        wake_evt = 1'b0, rd_stb = 1'b0;
    logic [31:0] status;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    uart_irq_aggregator i_uart_irq_aggregator (
        .clk(clk), .rst_n(rst_n),
        .req_line(req_line), .req_rx(req_rx), .req_tx(req_tx), .req_modem(req_modem),
        .ack(ack), .sleep(sleep), .wake_evt(wake_evt),
        .rd_stb(rd_stb), .rd_lane(rd_lane),
        .status(status), .irq(irq)
    );

    // reference model: flag bit 0 line, 1 rx, 2 tx, 3 modem
    logic [3:0] m_fl [4];
    logic       m_armed, m_wake;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) m_fl[c] <= '0;
            m_armed <= 1'b0;
            m_wake  <= 1'b0;
        end else begin
            bit fire;
            bit low;
            for (int c = 0; c < 4; c++) begin
                logic [3:0] r;
                r = {req_modem[c], req_tx[c], req_rx[c], req_line[c]};
                m_fl[c] <= ack[c] ? r : (m_fl[c] | r);
            end
            fire = m_armed && (wake_evt || sleep != 4'hF);
            low  = rd_stb && rd_lane[0];
            m_wake  <= fire || (m_wake && !low);
            m_armed <= fire ? 1'b0 : ((sleep == 4'hF) ? 1'b1 : m_armed);
        end
    end

    function automatic int exp_code(int c);
        if (c == 0 && m_wake) return 7;
        if (m_fl[c][0]) return 1;
        if (m_fl[c][1]) return 2;
        if (m_fl[c][2]) return 3;
        if (m_fl[c][3]) return 4;
        return 0;
    endfunction

    function automatic logic exp_bit(int c);
        return (m_fl[c] != 0) || (c == 0 && m_wake);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // advance one clock, then compare the whole word against the model
    task automatic cyc();
        logic [3:0] eb;
        @(negedge clk);
        chk("R4 reserved", {status[31:20], status[7:4]}, 32'h0);
        for (int c = 0; c < 4; c++) begin
            eb[c] = exp_bit(c);
            chk("R3 code", 32'(status[8+3*c +: 3]), 32'(exp_code(c)));
        end
        chk("R2 pending", 32'(status[3:0]), 32'(eb));
        chk("R11 irq", 32'(irq), 32'(|eb));
    endtask

    task automatic quiet();
        req_line = '0; req_rx = '0; req_tx = '0; req_modem = '0;
        ack = '0; wake_evt = 1'b0; rd_stb = 1'b0; rd_lane = '0;
    endtask

    initial begin
        #600000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset status", status, 32'h0);
        chk("R1 reset irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        cyc();

        // R3: receive request on channel 1
        req_rx[1] = 1'b1; cyc(); quiet();
        chk("R3 ch1 rx code", 32'(status[13:11]), 32'd2);
        chk("R2 ch1 bit", 32'(status[1]), 32'd1);

        // R6: whole-word read leaves channel state
        rd_stb = 1'b1; rd_lane = 4'hF; cyc(); quiet();
        chk("R6 after read", 32'(status[13:11]), 32'd2);
        cyc();
        chk("R6 still set", 32'(status[1]), 32'd1);

        // R3 priority, R5 ack and ack/request overlap
        req_line[1] = 1'b1; cyc(); quiet();
        chk("R3 line beats rx", 32'(status[13:11]), 32'd1);
        ack[1] = 1'b1; cyc(); quiet();
        chk("R5 ack clears", {29'b0, status[13:11]}, 32'd0);
        chk("R5 ack clears bit", 32'(status[1]), 32'd0);
        ack[1] = 1'b1; req_tx[1] = 1'b1; cyc(); quiet();
        chk("R5 request beats ack", 32'(status[13:11]), 32'd3);

        req_tx[2] = 1'b1; req_modem[2] = 1'b1; cyc(); quiet();
        chk("R3 tx beats modem", 32'(status[16:14]), 32'd3);
        ack[2] = 1'b1; cyc(); quiet();
        req_modem[2] = 1'b1; cyc(); quiet();
        chk("R3 modem code", 32'(status[16:14]), 32'd4);
        ack = 4'hF; cyc(); quiet();

        // R8: one channel stays awake
        sleep = 4'b0111; cyc();
        wake_evt = 1'b1; cyc(); quiet();
        sleep = 4'h0; cyc(); cyc();
        chk("R8 no wake code", 32'(status[10:8]), 32'd0);
        chk("R8 no wake irq", 32'(irq), 32'd0);

        // R7 / R9
        sleep = 4'hF; cyc(); cyc();
        chk("R7 not yet", 32'(status[0]), 32'd0);
        sleep = 4'b1110; cyc();
        chk("R7 wake code", 32'(status[10:8]), 32'd7);
        chk("R7 wake bit", 32'(status[0]), 32'd1);
        chk("R11 wake irq", 32'(irq), 32'd1);
        sleep = 4'h0; rd_stb = 1'b1; rd_lane = 4'b1110; cyc(); quiet();
        chk("R9 upper read keeps", 32'(status[10:8]), 32'd7);
        cyc();
        rd_stb = 1'b1; rd_lane = 4'b0001; cyc(); quiet();
        chk("R9 low read clears", 32'(status[10:8]), 32'd0);
        chk("R9 irq drops", 32'(irq), 32'd0);

        // R10: read races a new wake event
        sleep = 4'hF; cyc();
        wake_evt = 1'b1; rd_stb = 1'b1; rd_lane = 4'b0001; cyc(); quiet();
        chk("R10 wake kept", 32'(status[10:8]), 32'd7);
        rd_stb = 1'b1; rd_lane = 4'b0001; cyc(); quiet();
        chk("R9 cleared while asleep", 32'(status[0]), 32'd0);
        sleep = 4'h0; cyc();
        chk("R7 rearmed wake", 32'(status[10:8]), 32'd7);
        rd_stb = 1'b1; rd_lane = 4'b0001; cyc(); quiet();

        // mixed stimulus against the model
        for (int k = 0; k < 6000; k++) begin
            req_line  = 4'($urandom) & 4'($urandom) & 4'($urandom);
            req_rx    = 4'($urandom) & 4'($urandom) & 4'($urandom);
            req_tx    = 4'($urandom) & 4'($urandom) & 4'($urandom);
            req_modem = 4'($urandom) & 4'($urandom) & 4'($urandom);
            ack       = 4'($urandom) & 4'($urandom);
            wake_evt  = ($urandom % 24) == 0;
            rd_stb    = ($urandom % 4) == 0;
            rd_lane   = 4'($urandom);
            if (($urandom % 20) == 0) sleep = (($urandom % 2) == 0) ? 4'hF : 4'($urandom);
            cyc();
        end
        quiet();
        cyc();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule